// File: doc/BRIEF.md
# Serial Controller Register Bank

This block is the software-visible register file of a FIFO-equipped serial controller. A processor reaches it over a simple synchronous bus with one address, a write strobe, write data, a read strobe and registered read data. It holds the line mode, bit-rate divisor, control and port-pin registers and presents them to the rest of the controller as plain outputs. It also keeps five status flags: transmit-end, transmit-data-empty, break, receive-full and data-ready.

A write to the transmit data offset hands the byte to the transmitter as a one-cycle valid pulse. The receive FIFO block and a line break detector report events on single-cycle inputs, and these set the matching flags. Software clears a flag by writing 0 to its bit; writing 1 leaves it unchanged. Whenever transmit is enabled, reading the status register re-arms both transmit flags. The transmit interrupt follows a control bit. The receive interrupt is raised by a receive-full event and dropped by software. The error and break interrupt outputs are held low.

Top module: `sercfg_regs`

## Requirements
- R1: After reset the mode register reads 0x00, the bit-rate register 0xff, the control register 0x20, the port register 0x00 and the status register 0x60. Both interrupt outputs are low.
- R2: The mode register (offset 0x00) keeps write data ANDed with 0x7b. The bit-rate register (0x04) keeps the whole byte. The port register (0x20) keeps write data ANDed with 0xf3. All three read back at their offsets.
- R3: The control register (0x08) keeps write data ANDed with 0xfa. tx_irq equals control bit 7 from the cycle after the write.
- R4: A control write whose data bit 5 is 0 sets transmit-end (status bit 6).
- R5: A write to offset 0x0c gives tx_valid high for exactly the next cycle, with tx_data equal to the written byte, and clears transmit-data-empty (status bit 5).
- R6: Status (0x10) reads transmit-end in bit 6, transmit-data-empty in bit 5, break in bit 4, receive-full in bit 1 and data-ready in bit 0. Bits 7, 3 and 2 read 0.
- R7: A status write clears each of those five flags whose data bit is 0 and leaves unchanged each flag whose data bit is 1.
- R8: A status read returns the flags as they were before the read. If control bit 5 is set, transmit-end and transmit-data-empty are set from the next cycle. If control bit 5 is clear, the read changes nothing.
- R9: A pulse on brk_evt, rx_full_evt or rx_ready_evt sets break, receive-full or data-ready respectively. An event wins over a status-write clear in the same cycle.
- R10: rx_full_evt while control bit 6 is set raises rx_irq. rx_irq drops after a control write with data bit 6 at 0, or after a status write with data bit 1 or bit 0 at 0. A same-cycle raise wins over a drop.
- R11: Offset 0x24 and all unmapped offsets read 0, and so does 0x0c. Writes to 0x24 have no effect. A write to any offset other than 0x00, 0x04, 0x08, 0x0c, 0x10, 0x20 or 0x24 changes no state and gives bad_wr high for exactly one cycle.
- R12: err_irq and brk_irq stay 0.
- R13: bus_rdata carries the read value in the cycle after bus_rd and is 0 otherwise. A read in the same cycle as a write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_full_evt | input | 1 | Receive FIFO reached its trigger level |
| rx_ready_evt | input | 1 | Receive data ready indication |
| brk_evt | input | 1 | Line break detected |
| tx_valid | output | 1 | Transmit byte valid pulse |
| tx_data | output | 8 | Transmit byte |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Error interrupt, held low |
| brk_irq | output | 1 | Break interrupt, held low |
| bad_wr | output | 1 | Unmapped write pulse |
| mode_o | output | 8 | Mode register value |
| rate_o | output | 8 | Bit-rate register value |
| ctrl_o | output | 8 | Control register value |
| port_o | output | 8 | Port register value |

## Verification
The status flags are tried with all-zero, all-one and single-zero write patterns. These show that a 0 clears only its own flag and that a 1 preserves it. Status reads are issued with transmit enabled and disabled, which separates the value returned from the re-arm that follows the read. Events are made to collide with clearing writes, so that set-over-clear priority is visible. A long random mix of mapped, reserved and unmapped offsets, with random event pulses, is then compared every cycle against a behavioural model in the bench.

// File: rtl/sercfg_regs.sv
module sercfg_regs #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              rx_full_evt,
  input  logic              rx_ready_evt,
  input  logic              brk_evt,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              err_irq,
  output logic              brk_irq,
  output logic              bad_wr,
  output logic [7:0]        mode_o,
  output logic [7:0]        rate_o,
  output logic [7:0]        ctrl_o,
  output logic [7:0]        port_o
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_RATE = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'('h0c);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_PORT = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_RSVD = ADDR_W'('h24);
  localparam logic [7:0] M_MODE = 8'h7b;
  localparam logic [7:0] M_CTRL = 8'hfa;
  localparam logic [7:0] M_PORT = 8'hf3;

  // flag order: {tend, tde, brk, rdf, dr}
  logic [4:0] flags, flags_n, keep, set;
  logic       wr_ctrl, wr_stat, wr_txd, mapped, rearm, rxi_set, rxi_clr;
  logic [7:0] rd_val;

  assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
  assign wr_stat = bus_wr && bus_addr == A_STAT;
  assign wr_txd  = bus_wr && bus_addr == A_TXD;
  assign mapped  = bus_addr inside {A_MODE, A_RATE, A_CTRL, A_TXD, A_STAT, A_PORT, A_RSVD};
  assign rearm   = bus_rd && !bus_wr && bus_addr == A_STAT && ctrl_o[5];

  always_comb begin
    keep = wr_stat ? {bus_wdata[6], bus_wdata[5], bus_wdata[4], bus_wdata[1], bus_wdata[0]} : 5'b11111;
    if (wr_txd) keep[3] = 1'b0;
    set = {(wr_ctrl && !bus_wdata[5]) || rearm, rearm, brk_evt, rx_full_evt, rx_ready_evt};
    flags_n = (flags & keep) | set;
  end

  assign rxi_set = rx_full_evt && ctrl_o[6];
  assign rxi_clr = (wr_ctrl && !bus_wdata[6]) || (wr_stat && !(bus_wdata[1] && bus_wdata[0]));

  always_comb begin
    unique case (bus_addr)
      A_MODE:  rd_val = mode_o;
      A_RATE:  rd_val = rate_o;
      A_CTRL:  rd_val = ctrl_o;
      A_STAT:  rd_val = {1'b0, flags[4], flags[3], flags[2], 2'b00, flags[1], flags[0]};
      A_PORT:  rd_val = port_o;
      default: rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o    <= 8'h00;
      rate_o    <= 8'hff;
      ctrl_o    <= 8'h20;
      port_o    <= 8'h00;
      flags     <= 5'b11000;
      rx_irq    <= 1'b0;
      tx_valid  <= 1'b0;
      tx_data   <= 8'h00;
      bad_wr    <= 1'b0;
      bus_rdata <= 8'h00;
    end else begin
      flags     <= flags_n;
      rx_irq    <= rxi_set || (rx_irq && !rxi_clr);
      tx_valid  <= wr_txd;
      bad_wr    <= bus_wr && !mapped;
      bus_rdata <= (bus_rd && !bus_wr) ? rd_val : 8'h00;
      if (wr_txd) tx_data <= bus_wdata;
      if (bus_wr && bus_addr == A_MODE) mode_o <= bus_wdata & M_MODE;
      if (bus_wr && bus_addr == A_RATE) rate_o <= bus_wdata;
      if (wr_ctrl) ctrl_o <= bus_wdata & M_CTRL;
      if (bus_wr && bus_addr == A_PORT) port_o <= bus_wdata & M_PORT;
    end
  end

  assign tx_irq  = ctrl_o[7];
  assign err_irq = 1'b0;
  assign brk_irq = 1'b0;
endmodule

// File: rtl/sercfg_regs_chk.sv
module sercfg_regs_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              rx_full_evt,
  input logic              tx_valid,
  input logic              tx_irq,
  input logic              rx_irq,
  input logic              bad_wr,
  input logic [7:0]        mode_o
);
  a_r5_tx_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(bus_wr && bus_addr == ADDR_W'('h0c)));
  a_r3_tx_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'('h08)) |=> (tx_irq == $past(bus_wdata[7])));
  a_r11_bad_wr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |-> $past(bus_wr));
  a_r10_rx_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(rx_full_evt));
  a_r13_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> bus_rdata == 8'h00);
  a_r2_mode_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o & 8'h84) == 8'h00);
endmodule

bind sercfg_regs sercfg_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_full_evt(rx_full_evt),
  .tx_valid(tx_valid), .tx_irq(tx_irq), .rx_irq(rx_irq), .bad_wr(bad_wr), .mode_o(mode_o)
);

// File: tb/sercfg_regs_tb.sv
`timescale 1ns/1ps
module sercfg_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] a = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wd = '0;
  logic ef = 1'b0, ey = 1'b0, eb = 1'b0;
  logic [7:0] rdata, txd, mode, rate, ctrl, port;
  logic txv, txi, rxi, erri, brki, badw;

  always #2 clk = ~clk;

  sercfg_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(a), .bus_wr(wr), .bus_rd(rd), .bus_wdata(wd),
    .bus_rdata(rdata), .rx_full_evt(ef), .rx_ready_evt(ey), .brk_evt(eb),
    .tx_valid(txv), .tx_data(txd), .tx_irq(txi), .rx_irq(rxi), .err_irq(erri),
    .brk_irq(brki), .bad_wr(badw), .mode_o(mode), .rate_o(rate), .ctrl_o(ctrl), .port_o(port)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit started = 0;

  // behavioural reference model
  int m_mode, m_rate, m_ctrl, m_port, m_rdata, m_txd;
  bit m_tend, m_tde, m_brk, m_rdf, m_dr, m_rxi, m_txv, m_bad;

  function automatic int stat_val();
    return (m_tend ? 64 : 0) + (m_tde ? 32 : 0) + (m_brk ? 16 : 0) + (m_rdf ? 2 : 0) + (m_dr ? 1 : 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_rate = 255; m_ctrl = 32; m_port = 0; m_rdata = 0; m_txd = 0;
      m_tend = 1; m_tde = 1; m_brk = 0; m_rdf = 0; m_dr = 0; m_rxi = 0; m_txv = 0; m_bad = 0;
    end else begin
      bit rx_up, rx_dn, re;
      int ad;
      ad = int'(a);
      m_rdata = 0;
      re = 0;
      if (rd && !wr) begin
        case (ad)
          'h00: m_rdata = m_mode;
          'h04: m_rdata = m_rate;
          'h08: m_rdata = m_ctrl;
          'h10: begin m_rdata = stat_val(); re = (m_ctrl & 32) != 0; end
          'h20: m_rdata = m_port;
          default: m_rdata = 0;
        endcase
      end
      rx_up = ef && ((m_ctrl & 64) != 0);
      rx_dn = 0;
      m_txv = 0;
      m_bad = 0;
      if (wr) begin
        case (ad)
          'h00: m_mode = wd & 'h7b;
          'h04: m_rate = wd;
          'h08: begin
            m_ctrl = wd & 'hfa;
            if (!wd[5]) m_tend = 1;
            if (!wd[6]) rx_dn = 1;
          end
          'h0c: begin m_txv = 1; m_txd = wd; m_tde = 0; end
          'h10: begin
            if (!wd[6]) m_tend = 0;
            if (!wd[5]) m_tde = 0;
            if (!wd[4]) m_brk = 0;
            if (!wd[1]) m_rdf = 0;
            if (!wd[0]) m_dr = 0;
            if (!wd[1] || !wd[0]) rx_dn = 1;
          end
          'h20: m_port = wd & 'hf3;
          'h24: ;
          default: m_bad = 1;
        endcase
      end
      if (re) begin m_tend = 1; m_tde = 1; end
      if (eb) m_brk = 1;
      if (ef) m_rdf = 1;
      if (ey) m_dr = 1;
      if (rx_dn) m_rxi = 0;
      if (rx_up) m_rxi = 1;
      started = 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (started && rst_n) begin
      chk("R13 R6 R11 bus_rdata", rdata, m_rdata);
      chk("R5 tx_valid", txv, m_txv);
      if (m_txv) chk("R5 tx_data", txd, m_txd);
      chk("R3 tx_irq", txi, (m_ctrl >> 7) & 1);
      chk("R10 rx_irq", rxi, m_rxi);
      chk("R11 bad_wr", badw, m_bad);
      chk("R2 mode_o", mode, m_mode);
      chk("R2 rate_o", rate, m_rate);
      chk("R3 ctrl_o", ctrl, m_ctrl);
      chk("R2 port_o", port, m_port);
      chk("R12 err_irq", erri, 0);
      chk("R12 brk_irq", brki, 0);
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic op(bit w, bit r, logic [5:0] ad, logic [7:0] d, bit f = 0, bit y = 0, bit b = 0);
    @(posedge clk); #1;
    wr = w; rd = r; a = ad; wd = d; ef = f; ey = y; eb = b;
  endtask
  task automatic W(logic [5:0] ad, logic [7:0] d); op(1, 0, ad, d); endtask
  task automatic Rd(logic [5:0] ad); op(0, 1, ad, 8'h00); endtask
  task automatic idle(); op(0, 0, 6'h00, 8'h00); endtask
  task automatic expect_rd(logic [5:0] ad, int exp, string tag);
    Rd(ad); idle(); @(negedge clk); chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    expect_rd(6'h00, 'h00, "R1 mode reset");
    expect_rd(6'h04, 'hff, "R1 rate reset");
    expect_rd(6'h08, 'h20, "R1 ctrl reset");
    expect_rd(6'h20, 'h00, "R1 port reset");
    expect_rd(6'h10, 'h60, "R1 status reset");
    chk("R1 rx_irq reset", rxi, 0);
    // R2 masks
    W(6'h00, 8'hff); expect_rd(6'h00, 'h7b, "R2 mode mask");
    W(6'h04, 8'h5a); expect_rd(6'h04, 'h5a, "R2 rate full byte");
    W(6'h20, 8'hff); expect_rd(6'h20, 'hf3, "R2 port mask");
    // R5 transmit write, R8 re-arm with transmit enabled
    W(6'h0c, 8'ha5); idle(); @(negedge clk);
    expect_rd(6'h10, 'h40, "R5 R8 tde cleared before read");
    expect_rd(6'h10, 'h60, "R8 rearmed after read");
    // R7 clear, R8 no re-arm with bit5 clear, R4 tend set by control write
    W(6'h08, 8'h00); W(6'h10, 8'h00);
    expect_rd(6'h10, 'h00, "R7 all cleared");
    expect_rd(6'h10, 'h00, "R8 no rearm when disabled");
    W(6'h08, 8'h00); expect_rd(6'h10, 'h40, "R4 tend set");
    // R9 events, R6 layout, R7 selective clear
    op(0, 0, 6'h00, 8'h00, 1, 1, 1); idle();
    expect_rd(6'h10, 'h53, "R9 R6 events set flags");
    chk("R10 no irq when disabled", rxi, 0);
    W(6'h10, 8'hfd); expect_rd(6'h10, 'h51, "R7 clear rdf only");
    W(6'h10, 8'hef); expect_rd(6'h10, 'h41, "R7 clear brk only");
    // R10 receive interrupt, R3 tx_irq
    W(6'h08, 8'hc0); op(0, 0, 6'h00, 8'h00, 1); idle(); @(negedge clk);
    chk("R10 rx_irq raised", rxi, 1);
    chk("R3 tx_irq high", txi, 1);
    W(6'h10, 8'hfe); idle(); @(negedge clk);
    chk("R10 dropped by status write", rxi, 0);
    op(0, 0, 6'h00, 8'h00, 1); W(6'h08, 8'h80); idle(); @(negedge clk);
    chk("R10 dropped by control write", rxi, 0);
    W(6'h08, 8'hc0);
    op(1, 0, 6'h10, 8'h00, 1); idle(); @(negedge clk);
    chk("R10 raise wins", rxi, 1);
    expect_rd(6'h10, 'h02, "R9 set wins over clear");
    W(6'h08, 8'hff); expect_rd(6'h08, 'hfa, "R3 ctrl mask");
    // R11 reserved and unmapped
    W(6'h24, 8'hff); idle(); @(negedge clk); chk("R11 reserved no bad_wr", badw, 0);
    expect_rd(6'h24, 'h00, "R11 reserved reads 0");
    W(6'h30, 8'hab); idle(); @(negedge clk); chk("R11 bad_wr pulse", badw, 1);
    @(negedge clk); chk("R11 bad_wr one cycle", badw, 0);
    expect_rd(6'h30, 'h00, "R11 unmapped reads 0");
    expect_rd(6'h0c, 'h00, "R11 tx data reads 0");
    // R13 simultaneous read and write ignored
    op(1, 1, 6'h04, 8'h33); idle(); @(negedge clk); chk("R13 read with write ignored", rdata, 0);
    // random mix against the model
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] ad;
      int s;
      s = $urandom_range(0, 8);
      case (s)
        0: ad = 6'h00; 1: ad = 6'h04; 2: ad = 6'h08; 3: ad = 6'h0c; 4: ad = 6'h10;
        5: ad = 6'h14; 6: ad = 6'h20; 7: ad = 6'h24; default: ad = 6'h3c;
      endcase
      op($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, ad, 8'($urandom),
         $urandom_range(0, 4) == 0, $urandom_range(0, 4) == 0, $urandom_range(0, 6) == 0);
    end
    idle(); idle();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule